// File: doc/BRIEF.md
# Machine-Cycle Clock and Reset Controller

This block derives the machine-cycle timing of an 8-bit microcontroller core from the oscillator clock. A machine cycle lasts either 12 or 6 oscillator periods. A one-time-programmable fuse input, when set, forces the short cycle. When the fuse is clear, bit 0 of a special function register chooses the cycle length. The block emits a one-clock strobe at the start of every machine cycle and a phase count within the cycle. The active mode is also brought out so that the fixed-rate serial timing can follow the same divider.

The raw reset pin passes through a synchronizer and is then qualified against a minimum width of two machine cycles of the mode currently active. That is 12 oscillator periods in 6-clock mode and 24 in 12-clock mode. Once a pulse is accepted, the core reset stays asserted until the synchronized pin goes low. The external-access pin is captured at the moment the core reset is released, and it is ignored at all other times. The power-on input puts the block into the reset state, with the core held in reset until the pin is seen low.

Top module: `mcyc_clkrst_ctrl`

## Requirements
- R1: The clock-control register lives at SFR address 8Fh. Bit 0 reads back the last value written. Bits 7..1 always read 0, and writes to them are ignored. Reads at any other address return 00h, and writes to other addresses leave the register unchanged.
- R2: After power-on, the register reads 00h, `fast_mode` is 0, `core_rst` is 1 until the synchronized reset pin is seen low, and the strobe period is 12 oscillator clocks.
- R3: With `fuse_6clk`=1, the machine cycle is 6 clocks whatever bit 0 holds. With `fuse_6clk`=0, bit 0 = 1 gives 6 clocks and bit 0 = 0 gives 12 clocks. `fast_mode` reports 1 for 6-clock mode and 0 for 12-clock mode.
- R4: `mcyc_stb` is high for exactly one clock at the start of each machine cycle. `mcyc_phase` is 0 on the strobe clock and then counts 0, 1, 2, each value held for one third of the cycle.
- R5: A change of the requested mode takes effect only at the next machine-cycle boundary. The cycle in progress completes at its old length.
- R6: A reset pin pulse of at least 2 machine cycles of the active mode (12 clocks in 6-clock mode, 24 in 12-clock mode) asserts `core_rst`. A pulse one clock shorter has no effect.
- R7: Once accepted, `core_rst` stays high while the synchronized pin is high and falls within three clocks of the pin going low.
- R8: `ea_latched` takes the value of `ea_pin` at the release of `core_rst`. Later changes of `ea_pin` are ignored.
- R9: While `core_rst` is high, bit 0 is held at 0 and SFR writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| fuse_6clk | input | 1 | Programmed fuse forcing 6-clock mode |
| rst_pin | input | 1 | Raw external reset pin, active high, asynchronous |
| ea_pin | input | 1 | External-access pin |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| mcyc_stb | output | 1 | Start-of-machine-cycle strobe |
| mcyc_phase | output | 2 | Phase within the machine cycle (0..2) |
| fast_mode | output | 1 | Active mode, 1 = 6 clocks per cycle |
| core_rst | output | 1 | Qualified core reset |
| ea_latched | output | 1 | External-access value captured at reset release |

## Verification
The assertions assume three things about the inputs. The fuse and the SFR bit may change at any clock. `rst_pin` may be asynchronous, since only its synchronized copy is checked. `ea_pin` is free to toggle, because only the captured value is checked for stability. The stimulus changes every input on the falling clock edge and settles the mode for several machine cycles before each reset pulse, so the width threshold in force during a pulse is never in transition. Pulse widths are chosen one clock below and exactly at each mode's threshold.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
   localparam int unsigned MC_SLOW_DEF  = 12;
   localparam int unsigned MC_FAST_DEF  = 6;
   localparam int unsigned MC_PHASES    = 3;
   localparam int unsigned RST_MIN_DEF  = 2;
   localparam int unsigned SYNC_DEF     = 2;
   localparam logic [7:0]  CKREG_ADDR   = 8'h8F;

   typedef enum logic {
      MODE_SLOW = 1'b0,
      MODE_FAST = 1'b1
   } mc_mode_e;
endpackage

// File: rtl/mcyc_ckreg.sv
module mcyc_ckreg #(
   parameter logic [7:0] ADDR = mcyc_pkg::CKREG_ADDR
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       core_rst,
   input  logic [7:0] addr,
   input  logic       wr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       div_sel
);
   logic sel_q;
   logic hit;

   assign hit = (addr == ADDR);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)             sel_q <= 1'b0;
      else if (core_rst)      sel_q <= 1'b0;
      else if (wr && hit)     sel_q <= wdata[0];
   end

   assign rdata   = hit ? {7'b0, sel_q} : 8'h00;
   assign div_sel = sel_q;

   p_write_readback_r1: assert property (@(posedge clk) disable iff (!por_n)
      (wr && hit && !core_rst) |=> (rdata == ($past(wdata) & 8'h01)));
   p_other_addr_ignored_r1: assert property (@(posedge clk) disable iff (!por_n)
      (wr && !hit && !core_rst) |=> $stable(sel_q));
   p_clear_in_reset_r9: assert property (@(posedge clk) disable iff (!por_n)
      core_rst |=> !sel_q);
endmodule

// File: rtl/mcyc_cycle_gen.sv
module mcyc_cycle_gen #(
   parameter int unsigned SLOW = mcyc_pkg::MC_SLOW_DEF,
   parameter int unsigned FAST = mcyc_pkg::MC_FAST_DEF
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       req_fast,
   output logic       stb,
   output logic [1:0] phase,
   output logic       fast_q
);
   localparam int unsigned LW     = $clog2(SLOW);
   localparam int unsigned STEP_S = SLOW / mcyc_pkg::MC_PHASES;
   localparam int unsigned STEP_F = FAST / mcyc_pkg::MC_PHASES;
   localparam bit POW2 = ((STEP_S & (STEP_S - 1)) == 0) && ((STEP_F & (STEP_F - 1)) == 0);

   if (SLOW % mcyc_pkg::MC_PHASES != 0) begin : g_bad_slow
      $error("SLOW must be a multiple of the phase count");
   end
   if (FAST % mcyc_pkg::MC_PHASES != 0) begin : g_bad_fast
      $error("FAST must be a multiple of the phase count");
   end
   if (FAST >= SLOW || FAST < mcyc_pkg::MC_PHASES) begin : g_bad_order
      $error("FAST must be at least the phase count and below SLOW");
   end

   logic [LW-1:0] cnt;
   logic          at_last;

   assign at_last = fast_q ? (cnt == LW'(FAST - 1)) : (cnt == LW'(SLOW - 1));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt    <= '0;
         fast_q <= mcyc_pkg::MODE_SLOW;
      end else if (at_last) begin
         cnt    <= '0;
         fast_q <= req_fast;
      end else begin
         cnt    <= cnt + 1'b1;
      end
   end

   assign stb = (cnt == '0);

   if (POW2) begin : g_phase_shift
      always_comb begin
         phase = fast_q ? 2'(cnt >> $clog2(STEP_F)) : 2'(cnt >> $clog2(STEP_S));
      end
   end else begin : g_phase_div
      always_comb begin
         phase = fast_q ? 2'(cnt / LW'(STEP_F)) : 2'(cnt / LW'(STEP_S));
      end
   end

   p_stb_single_r4: assert property (@(posedge clk) disable iff (!por_n)
      stb |=> !stb);
   p_phase_step_r4: assert property (@(posedge clk) disable iff (!por_n)
      !stb |-> (phase == $past(phase) || phase == $past(phase) + 2'd1));
   p_strobe_phase_r4: assert property (@(posedge clk) disable iff (!por_n)
      stb |=> (phase == 2'd0));
   p_mode_at_boundary_r5: assert property (@(posedge clk) disable iff (!por_n)
      (fast_q != $past(fast_q)) |-> stb);
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (!por_n)
      fast_q |-> (cnt < LW'(FAST)));
endmodule

// File: rtl/mcyc_rst_filter.sv
module mcyc_rst_filter #(
   parameter int unsigned STAGES = mcyc_pkg::SYNC_DEF,
   parameter int unsigned MIN_MC = mcyc_pkg::RST_MIN_DEF,
   parameter int unsigned SLOW   = mcyc_pkg::MC_SLOW_DEF,
   parameter int unsigned FAST   = mcyc_pkg::MC_FAST_DEF
) (
   input  logic clk,
   input  logic por_n,
   input  logic fast,
   input  logic rst_pin,
   input  logic ea_pin,
   output logic core_rst,
   output logic ea_q
);
   localparam int unsigned THR_S = MIN_MC * SLOW;
   localparam int unsigned THR_F = MIN_MC * FAST;
   localparam int unsigned CW    = $clog2(THR_S + 1);

   if (STAGES < 2) begin : g_bad_sync
      $error("STAGES must be at least 2");
   end
   if (MIN_MC < 1) begin : g_bad_min
      $error("MIN_MC must be at least 1");
   end

   logic [STAGES-1:0] sync_q;
   logic              rst_s;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sync_q <= '0;
      else        sync_q <= {sync_q[STAGES-2:0], rst_pin};
   end
   assign rst_s = sync_q[STAGES-1];

   logic [CW-1:0] hi_cnt;
   logic [CW:0]   hi_nxt;
   logic [CW:0]   thr;
   logic          acc;

   assign hi_nxt = {1'b0, hi_cnt} + 1'b1;
   assign thr    = fast ? (CW+1)'(THR_F) : (CW+1)'(THR_S);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         hi_cnt <= '0;
         acc    <= 1'b1;
         ea_q   <= 1'b0;
      end else if (rst_s) begin
         if (hi_nxt <= (CW+1)'(THR_S)) hi_cnt <= hi_nxt[CW-1:0];
         if (hi_nxt >= thr)            acc    <= 1'b1;
      end else begin
         hi_cnt <= '0;
         if (acc) begin
            acc  <= 1'b0;
            ea_q <= ea_pin;
         end
      end
   end

   assign core_rst = acc;

   p_accept_needs_high_r6: assert property (@(posedge clk) disable iff (!por_n)
      $rose(acc) |-> $past(rst_s));
   p_release_needs_low_r7: assert property (@(posedge clk) disable iff (!por_n)
      $fell(acc) |-> !$past(rst_s));
   p_ea_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
      (!acc && !$past(acc)) |-> $stable(ea_q));
endmodule

// File: rtl/mcyc_clkrst_ctrl.sv
module mcyc_clkrst_ctrl #(
   parameter int unsigned MC_SLOW     = mcyc_pkg::MC_SLOW_DEF,
   parameter int unsigned MC_FAST     = mcyc_pkg::MC_FAST_DEF,
   parameter int unsigned RST_MIN_MC  = mcyc_pkg::RST_MIN_DEF,
   parameter int unsigned SYNC_STAGES = mcyc_pkg::SYNC_DEF,
   parameter logic [7:0]  REG_ADDR    = mcyc_pkg::CKREG_ADDR
) (
   input  logic       clk_osc,
   input  logic       por_n,
   input  logic       fuse_6clk,
   input  logic       rst_pin,
   input  logic       ea_pin,
   input  logic [7:0] sfr_addr,
   input  logic       sfr_wr,
   input  logic [7:0] sfr_wdata,
   output logic [7:0] sfr_rdata,
   output logic       mcyc_stb,
   output logic [1:0] mcyc_phase,
   output logic       fast_mode,
   output logic       core_rst,
   output logic       ea_latched
);
   logic div_sel;
   logic req_fast;

   assign req_fast = fuse_6clk | div_sel;

   mcyc_ckreg #(.ADDR(REG_ADDR)) u_ckreg (
      .clk(clk_osc), .por_n(por_n), .core_rst(core_rst),
      .addr(sfr_addr), .wr(sfr_wr), .wdata(sfr_wdata),
      .rdata(sfr_rdata), .div_sel(div_sel)
   );

   mcyc_cycle_gen #(.SLOW(MC_SLOW), .FAST(MC_FAST)) u_cycle (
      .clk(clk_osc), .por_n(por_n), .req_fast(req_fast),
      .stb(mcyc_stb), .phase(mcyc_phase), .fast_q(fast_mode)
   );

   mcyc_rst_filter #(.STAGES(SYNC_STAGES), .MIN_MC(RST_MIN_MC),
                     .SLOW(MC_SLOW), .FAST(MC_FAST)) u_rstf (
      .clk(clk_osc), .por_n(por_n), .fast(fast_mode),
      .rst_pin(rst_pin), .ea_pin(ea_pin),
      .core_rst(core_rst), .ea_q(ea_latched)
   );

   p_fuse_forces_fast_r3: assert property (@(posedge clk_osc) disable iff (!por_n)
      (mcyc_stb && $past(fuse_6clk)) |-> fast_mode);
endmodule

// File: tb/mcyc_clkrst_ctrl_tb.sv
module mcyc_clkrst_ctrl_tb_top;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic       fuse;
      logic       x2;
      logic [5:0] width;
      logic       accept;
      logic [4:0] period;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{fuse:1'b0, x2:1'b0, width:6'd23, accept:1'b0, period:5'd12},
      '{fuse:1'b0, x2:1'b0, width:6'd24, accept:1'b1, period:5'd12},
      '{fuse:1'b0, x2:1'b1, width:6'd11, accept:1'b0, period:5'd6},
      '{fuse:1'b0, x2:1'b1, width:6'd12, accept:1'b1, period:5'd6},
      '{fuse:1'b1, x2:1'b0, width:6'd11, accept:1'b0, period:5'd6},
      '{fuse:1'b1, x2:1'b1, width:6'd12, accept:1'b1, period:5'd6}
   };

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       fuse_6clk = 1'b0;
   logic       rst_pin = 1'b0;
   logic       ea_pin = 1'b0;
   logic [7:0] sfr_addr = 8'h00;
   logic       sfr_wr = 1'b0;
   logic [7:0] sfr_wdata = 8'h00;
   logic [7:0] sfr_rdata;
   logic       mcyc_stb;
   logic [1:0] mcyc_phase;
   logic       fast_mode;
   logic       core_rst;
   logic       ea_latched;

   always #(CLK_P/2) clk = ~clk;

   mcyc_clkrst_ctrl dut_i (
      .clk_osc(clk), .por_n(por_n), .fuse_6clk(fuse_6clk), .rst_pin(rst_pin),
      .ea_pin(ea_pin), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
      .sfr_rdata(sfr_rdata), .mcyc_stb(mcyc_stb), .mcyc_phase(mcyc_phase),
      .fast_mode(fast_mode), .core_rst(core_rst), .ea_latched(ea_latched)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int last_stb = 0;
   int gap = 0;
   int nstb = 0;
   int seen_rst = 0;
   int phase_on = 0;
   int phase_err = 0;
   int exp_period = 12;

   always @(negedge clk) begin
      cyc++;
      if (phase_on != 0) begin
         int k;
         int ep;
         k  = mcyc_stb ? 0 : (cyc - last_stb);
         ep = k / (exp_period / 3);
         if (int'(mcyc_phase) != ep) phase_err++;
      end
      if (mcyc_stb) begin
         gap = cyc - last_stb;
         last_stb = cyc;
         nstb++;
      end
      if (core_rst) seen_rst = 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
      sfr_addr  = a;
      sfr_wdata = d;
      sfr_wr    = 1'b1;
      @(negedge clk);
      sfr_wr    = 1'b0;
   endtask

   task automatic sfr_read(input logic [7:0] a, output int v);
      sfr_addr = a;
      #1;
      v = int'(sfr_rdata);
   endtask

   task automatic wait_stb();
      int n0;
      n0 = nstb;
      while (nstb == n0) @(negedge clk);
   endtask

   task automatic pulse(input int w);
      rst_pin = 1'b1;
      repeat (w) @(negedge clk);
      rst_pin = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int v;
      // R2: power-on state
      repeat (3) @(negedge clk);
      chk("R2 core_rst during power-on", int'(core_rst), 1);
      sfr_read(8'h8F, v);
      chk("R2 register at power-on", v, 0);
      por_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R2 core_rst released", int'(core_rst), 0);
      chk("R2 fast_mode after reset", int'(fast_mode), 0);
      wait_stb(); wait_stb();
      chk("R2 period after reset", gap, 12);

      // Table: mode combinations, period, phase and reset width thresholds
      foreach (VECS[i]) begin
         vec_t vv;
         vv = VECS[i];
         fuse_6clk = vv.fuse;
         sfr_write(8'h8F, {7'h7F, vv.x2});
         repeat (30) @(negedge clk);
         exp_period = int'(vv.period);
         chk("R3 fast_mode", int'(fast_mode), (vv.period == 5'd6) ? 1 : 0);
         sfr_read(8'h8F, v);
         chk("R1 readback with reserved bits written", v, int'(vv.x2));
         wait_stb();
         phase_on = 1;
         wait_stb(); wait_stb();
         phase_on = 0;
         chk("R3 machine cycle period", gap, int'(vv.period));
         chk("R4 phase sequence errors", phase_err, 0);
         seen_rst = 0;
         pulse(int'(vv.width));
         repeat (10) @(negedge clk);
         chk("R6 reset accepted at width", seen_rst, int'(vv.accept));
         sfr_read(8'h8F, v);
         chk("R9 register after pulse", v, vv.accept ? 0 : int'(vv.x2));
      end

      // R1: other address ignored
      fuse_6clk = 1'b0;
      sfr_write(8'h8F, 8'h00);
      sfr_write(8'h8E, 8'h01);
      sfr_read(8'h8F, v);
      chk("R1 write to other address ignored", v, 0);
      sfr_read(8'h8E, v);
      chk("R1 other address reads zero", v, 0);

      // R5: mode change at boundary
      repeat (30) @(negedge clk);
      wait_stb();
      sfr_write(8'h8F, 8'h01);
      wait_stb();
      chk("R5 current cycle keeps old length", gap, 12);
      wait_stb();
      chk("R5 next cycle uses new length", gap, 6);

      // R7, R8, R9: long reset, EA capture, writes ignored in reset
      repeat (20) @(negedge clk);
      ea_pin  = 1'b1;
      rst_pin = 1'b1;
      repeat (20) @(negedge clk);
      chk("R7 core_rst held during pin high", int'(core_rst), 1);
      sfr_write(8'h8F, 8'h01);
      repeat (19) @(negedge clk);
      rst_pin = 1'b0;
      @(negedge clk);
      chk("R7 core_rst still held just after pin fall", int'(core_rst), 1);
      repeat (3) @(negedge clk);
      chk("R7 core_rst released after pin low", int'(core_rst), 0);
      chk("R8 ea captured at release", int'(ea_latched), 1);
      sfr_read(8'h8F, v);
      chk("R9 write during reset ignored", v, 0);
      ea_pin = 1'b0;
      repeat (10) @(negedge clk);
      chk("R8 later ea change ignored", int'(ea_latched), 1);
      pulse(30);
      repeat (6) @(negedge clk);
      chk("R8 ea recaptured on next release", int'(ea_latched), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule